// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps one status byte for each finished transmission. The bytes are held in a small last-in-first-out stack. The transmit engine raises a one-cycle completion event that carries its result flags. The block packs those flags into a status record and pushes the record. The host sees the most recent record on a byte-wide read path. A host write strobe to the status register pops that record, and the older entry then becomes visible.

The stack has a fixed depth. A completion event that arrives while the stack is full keeps the records already stored. It drops the new record and marks the loss in the overflow bit of the visible entry. A transmit reset input empties the stack in one cycle.

Storage is registered and the read path is combinational from the stack pointer. A push, pop or reset therefore shows on the outputs just after the clock edge that takes it.

Top module: `txs_status_stack`

## Requirements
- R1: Status byte layout: bit 7 complete (always 1 in a stored record), bit 6 interrupt-on-success requested, bit 5 jabber error, bit 4 underrun, bit 3 collision limit reached, bit 2 stack overflow, and bits 1 and 0 read as 0.
- R2: The stack holds up to DEPTH records (default 4). `status_o` always shows the most recently pushed record that has not been popped. It updates at the clock edge that takes the completion event.
- R3: A pop strobe without a completion event removes the top record. The record below it is visible after that clock edge.
- R4: When the stack is empty, `status_o` reads 0x00, so the complete bit is clear. A pop on an empty stack has no effect.
- R5: A completion event on a full stack without a pop drops the new record and sets bit 2 of the top entry. No other bit changes. Popping that entry exposes the entry below it, which keeps its own bit 2.
- R6: A completion event and a pop in the same cycle replace the top record with the new one, and the depth does not change. On an empty stack, the pair simply pushes the new record.
- R7: `xmit_reset_i` empties the stack at the next edge. It takes priority over a completion event and a pop in the same cycle.
- R8: `overflow_o` always equals bit 2 of `status_o`. The active-low asynchronous reset `rst_ni` leaves the stack empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xmit_reset_i | input | 1 | Transmit reset; clears the stack |
| done_i | input | 1 | Completion event from the transmit engine |
| irq_req_i | input | 1 | Interrupt on success was requested |
| jabber_i | input | 1 | Jabber error flag |
| underrun_i | input | 1 | Underrun flag |
| max_coll_i | input | 1 | Collision limit reached flag |
| pop_i | input | 1 | Host write strobe to the status register |
| status_o | output | 8 | Top status record, zero when empty |
| overflow_o | output | 1 | Overflow bit of the visible record |

## Verification
A completion event and a host pop can fall in the same cycle. The transmit reset can also coincide with both. The bench drives these pairs on purpose: an event with a pop on a partly filled stack, on an empty stack and on a full stack, and a transmit reset with an event and a pop. A behavioural queue model computes the expected top byte every cycle. The model checks that a replacement keeps the depth unchanged, that an empty-stack pair becomes a push, and that reset wins.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef struct packed {
    logic       complete;
    logic       irq_req;
    logic       jabber;
    logic       underrun;
    logic       max_coll;
    logic       overflow;
    logic [1:0] rsvd;
  } txs_rec_t;

  localparam int unsigned REC_W   = $bits(txs_rec_t);
  localparam int unsigned OVF_BIT = 2;
endpackage

// File: rtl/txs_record_fmt.sv
module txs_record_fmt
  import txs_pkg::*;
(
  input  logic     irq_req_i,
  input  logic     jabber_i,
  input  logic     underrun_i,
  input  logic     max_coll_i,
  output txs_rec_t rec_o
);
  always_comb begin
    rec_o          = '0;
    rec_o.complete = 1'b1;
    rec_o.irq_req  = irq_req_i;
    rec_o.jabber   = jabber_i;
    rec_o.underrun = underrun_i;
    rec_o.max_coll = max_coll_i;
  end
endmodule

// File: rtl/txs_entry_store.sv
module txs_entry_store
  import txs_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic             ovf_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  txs_rec_t         wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output txs_rec_t         rd_data_o
);
  txs_rec_t mem_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[k] <= '0;
      else if (clr_i)                                mem_q[k] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(k))     mem_q[k] <= wr_data_i;
      else if (ovf_en_i && wr_idx_i == IDX_W'(k))    mem_q[k].overflow <= 1'b1;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/txs_status_stack.sv
module txs_status_stack
  import txs_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       xmit_reset_i,
  input  logic       done_i,
  input  logic       irq_req_i,
  input  logic       jabber_i,
  input  logic       underrun_i,
  input  logic       max_coll_i,
  input  logic       pop_i,
  output logic [7:0] status_o,
  output logic       overflow_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] wr_idx, top_idx;
  logic             wr_en, ovf_en, full, empty;
  txs_rec_t         new_rec, top_rec;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign top_idx = IDX_W'(cnt_q - 1'b1);

  txs_record_fmt u_fmt (
    .irq_req_i (irq_req_i),
    .jabber_i  (jabber_i),
    .underrun_i(underrun_i),
    .max_coll_i(max_coll_i),
    .rec_o     (new_rec)
  );

  always_comb begin
    cnt_d  = cnt_q;
    wr_en  = 1'b0;
    ovf_en = 1'b0;
    wr_idx = top_idx;
    if (xmit_reset_i) begin
      cnt_d = '0;
    end else if (done_i) begin
      if (pop_i && !empty) begin
        wr_en = 1'b1;                 // replace top
      end else if (!full) begin
        wr_en  = 1'b1;
        wr_idx = IDX_W'(cnt_q);
        cnt_d  = cnt_q + 1'b1;
      end else begin
        ovf_en = 1'b1;                // drop record, flag loss
      end
    end else if (pop_i && !empty) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  txs_entry_store #(.DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (xmit_reset_i),
    .wr_en_i  (wr_en),
    .ovf_en_i (ovf_en),
    .wr_idx_i (wr_idx),
    .wr_data_i(new_rec),
    .rd_idx_i (top_idx),
    .rd_data_o(top_rec)
  );

  assign status_o   = empty ? 8'h00 : top_rec;
  assign overflow_o = status_o[OVF_BIT];

  // R2: depth bounded
  a_r2_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  // R1: any visible record carries the complete bit, low bits zero
  a_r1_layout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 8'h00) |-> (status_o[7] && status_o[1:0] == 2'b00));

  // R2: a push shows the new flags next cycle
  a_r2_push_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !xmit_reset_i && (!full || pop_i)) |=>
      (status_o[7:3] == {1'b1, $past(irq_req_i), $past(jabber_i),
                         $past(underrun_i), $past(max_coll_i)}) && !status_o[2]);

  // R5: full stack event keeps top flags and sets overflow
  a_r5_overflow_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && full && !pop_i && !xmit_reset_i) |=>
      (status_o[7:3] == $past(status_o[7:3])) && status_o[2] && $stable(cnt_q));

  // R3: lone pop shrinks depth by one
  a_r3_pop_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !done_i && !xmit_reset_i && !empty) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R7: transmit reset empties the stack
  a_r7_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xmit_reset_i |=> status_o == 8'h00);
endmodule

// File: tb/txs_status_stack_tb_top.sv
`timescale 1ns/1ps
module txs_status_stack_tb_top;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xr = 0, done = 0, irq = 0, jab = 0, und = 0, mc = 0, pop = 0;
  logic [7:0] status;
  logic ovf;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] q[$];

  always #2.5 clk = ~clk;

  txs_status_stack #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .xmit_reset_i(xr), .done_i(done),
    .irq_req_i(irq), .jabber_i(jab), .underrun_i(und), .max_coll_i(mc),
    .pop_i(pop), .status_o(status), .overflow_o(ovf)
  );

  function automatic logic [7:0] exp_top();
    return (q.size() == 0) ? 8'h00 : q[q.size()-1];
  endfunction

  task automatic check(input string tag);
    logic [7:0] e;
    e = exp_top();
    n_checks++;
    if (status !== e) begin
      n_fail++;
      $display("FAIL %s status actual=%02h expected=%02h", tag, status, e);
    end
    n_checks++;
    if (ovf !== e[2]) begin
      n_fail++;
      $display("FAIL R8 overflow_o actual=%0b expected=%0b", ovf, e[2]);
    end
  endtask

  task automatic model_step();
    logic [7:0] rec;
    rec = {1'b1, irq, jab, und, mc, 3'b000};
    if (xr) q.delete();
    else if (done) begin
      if (pop && q.size() > 0) q[q.size()-1] = rec;
      else if (q.size() < DEPTH) q.push_back(rec);
      else q[q.size()-1][2] = 1'b1;
    end else if (pop && q.size() > 0) void'(q.pop_back());
  endtask

  task automatic cyc(input logic d, input logic [3:0] fl, input logic p,
                     input logic r, input string tag);
    @(negedge clk);
    done = d; {irq, jab, und, mc} = fl; pop = p; xr = r;
    @(posedge clk);
    model_step();
    #1 check(tag);
  endtask

  initial begin
    #1 check("R8 reset state");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R4 empty after reset");
    cyc(0, 4'h0, 1, 0, "R4 pop on empty");
    cyc(1, 4'b1000, 0, 0, "R1 push irq");
    cyc(1, 4'b0100, 0, 0, "R1 push jabber");
    cyc(1, 4'b0011, 0, 0, "R2 push underrun+coll");
    cyc(0, 4'h0, 1, 0, "R3 pop exposes older");
    cyc(0, 4'h0, 1, 0, "R3 pop again");
    cyc(0, 4'h0, 1, 0, "R4 pop to empty");
    cyc(0, 4'h0, 1, 0, "R4 pop on empty again");
    cyc(1, 4'b1010, 1, 0, "R6 push+pop on empty");
    cyc(1, 4'b0101, 0, 0, "R2 push");
    cyc(1, 4'b1111, 1, 0, "R6 replace top");
    cyc(0, 4'h0, 1, 0, "R6 depth unchanged");
    cyc(1, 4'b0001, 0, 0, "R2 fill");
    cyc(1, 4'b0010, 0, 0, "R2 fill");
    cyc(1, 4'b0100, 0, 0, "R2 fill to full");
    cyc(1, 4'b1111, 0, 0, "R5 overflow drop");
    cyc(1, 4'b0000, 0, 0, "R5 overflow again");
    cyc(0, 4'h0, 0, 0, "R5 idle hold");
    cyc(1, 4'b1000, 1, 0, "R6 replace on full");
    cyc(1, 4'b0011, 0, 0, "R5 overflow after replace");
    cyc(0, 4'h0, 1, 0, "R5 pop exposes clean entry");
    cyc(1, 4'b1100, 1, 1, "R7 reset beats event+pop");
    cyc(0, 4'h0, 0, 0, "R7 stays empty");
    cyc(1, 4'b0110, 0, 0, "R2 push after reset");
    cyc(0, 4'h0, 0, 1, "R7 reset alone");
    for (int i = 0; i < 40; i++)
      cyc(((i * 7) % 3) != 0, 4'((i * 5) % 16), ((i * 3) % 4) == 1,
          (i % 17) == 16, "R2 mixed traffic");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule